// File: doc/BRIEF.md
# Indirect Clock-Configuration Register Bridge

This block gives a host byte-wide access to a small file of clock-generator configuration registers through two ports that share one bus. The host first writes an address/control byte that holds the register index in bits 7:2 and a write-enable flag in bit 1. It then touches the data port. A data read returns the register that the latched index selects. A data write stores the byte only while the write-enable flag is set. A complete host write therefore takes three bus cycles: set the index with the flag on, write the data, then rewrite the index with the flag off.

Combinational outputs feed the clock generator. The block decodes the register file into the settings for one selected pixel clock. The feedback divider for pixel clock n sits at index FB_BASE+n. Its 3-bit post-divider code is assembled from two registers: a 2-bit field at bits 2n+1:2n of the post-divider register, and an extra high bit at bit 4+n of the extended post-divider register. The low three bits of the extended register give the memory-clock post-divider select. The reference divider register resets to a nonzero default. Every other register resets to zero.

Top module: `pll_cfg_bridge`

## Requirements
- R1: After reset, every register reads zero except the reference divider, which reads REF_RST. Both the address byte and host_rdata read zero.
- R2: A write with host_sel=0 latches the address byte: bits 7:2 are the index and bit 1 is write enable. Bit 0 always reads zero. A read with host_sel=0 returns the latched byte.
- R3: A write with host_sel=1 while write enable is set stores all 8 bits into the register at the latched index.
- R4: A write with host_sel=1 while write enable is clear has no effect on any register.
- R5: A read with host_rd=1 registers its result into host_rdata on that clock edge, so the value is visible one cycle later. host_rdata holds that value until the next read.
- R6: An index at or above REG_COUNT reads as zero, and a data write to it changes no register.
- R7: pclk_fb_div equals the register at index FB_BASE+pclk_sel.
- R8: pclk_post_code equals {EXT[4+n], POST[2n+1:2n]} with n=pclk_sel, where POST is the register at POST_IDX and EXT is the register at EXT_IDX.
- R9: mclk_post_sel equals EXT[2:0], and ref_div equals the register at REF_IDX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | 0 selects the address/control port, 1 selects the data port |
| host_wr | input | 1 | Write strobe for the selected port |
| host_rd | input | 1 | Read strobe for the selected port |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Registered read data |
| pclk_sel | input | 2 | Pixel clock whose settings are decoded |
| pclk_fb_div | output | 8 | Feedback divider of the selected pixel clock |
| pclk_post_code | output | 3 | Post-divider code of the selected pixel clock |
| mclk_post_sel | output | 3 | Memory-clock post-divider select |
| ref_div | output | 8 | Reference divider |

## Verification
The bench builds the block with its default parameters. The 6-bit index then spans 64 values against a file of 16 registers, so random indices regularly land out of range and exercise the ignored-write and zero-read paths. With the default layout (reference divider at 2, post-divider at 5, extended control at 6, feedback dividers at 7 to 10), random writes reach every decoded field. Sweeping pclk_sel over all four pixel clocks checks the per-clock bit positions, including the extra post-divider bits 4 to 7.

// File: rtl/pllb_pkg.sv
package pllb_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_PCLK = 4;

  // LSB of pixel clock n's 2-bit field in the post-divider register
  function automatic int post_lsb(input int n);
    return 2 * n;
  endfunction

  // Extra post-divider bit of pixel clock n in the extended register
  function automatic int ext_bit(input int n);
    return 4 + n;
  endfunction

  // Address/control byte as stored: bit 0 forced to zero
  function automatic logic [7:0] addr_clean(input logic [7:0] b);
    return {b[7:1], 1'b0};
  endfunction
endpackage

// File: rtl/pllb_addr_port.sv
module pllb_addr_port #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ev,
  input  logic [7:0]       wdata,
  output logic [7:0]       addr_byte,
  output logic [IDX_W-1:0] idx,
  output logic             we
);
  import pllb_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_byte <= '0;
    else if (wr_ev) addr_byte <= addr_clean(wdata);
  end

  assign idx = addr_byte[2 +: IDX_W];
  assign we  = addr_byte[1];

  p_addr_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> (addr_byte[7:1] == $past(wdata[7:1])) && (addr_byte[0] == 1'b0));
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ev |=> $stable(addr_byte));
endmodule

// File: rtl/pllb_regfile.sv
module pllb_regfile #(
  parameter int         IDX_W     = 6,
  parameter int         REG_COUNT = 16,
  parameter int         REF_IDX   = 2,
  parameter logic [7:0] REF_RST   = 8'h40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_ev,
  input  logic                   we,
  input  logic [IDX_W-1:0]       idx,
  input  logic [7:0]             wdata,
  output logic [7:0]             rd_word,
  output logic [REG_COUNT*8-1:0] file_flat
);
  localparam int FLAT_W = REG_COUNT * 8;

  logic [7:0] regs [REG_COUNT];
  logic       in_range;
  logic       store;

  assign in_range = (idx < IDX_W'(REG_COUNT));
  assign store    = wr_ev && we && in_range;

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    localparam logic [7:0] RST_V = (g == REF_IDX) ? REF_RST : 8'h00;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             regs[g] <= RST_V;
      else if (store && idx == IDX_W'(g))     regs[g] <= wdata;
    end
    assign file_flat[g*8 +: 8] = regs[g];
  end

  always_comb begin
    rd_word = 8'h00;
    for (int i = 0; i < REG_COUNT; i++)
      if (idx == IDX_W'(i)) rd_word = regs[i];
  end

  p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && we && in_range) |=> (rd_word == $past(wdata)));
  p_no_we_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && !we) |=> $stable(file_flat));
  p_oob_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && !in_range) |=> $stable(file_flat));
  p_oob_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |-> (rd_word == 8'h00));

  logic [FLAT_W-1:0] unused_chk;
  assign unused_chk = file_flat;
endmodule

// File: rtl/pllb_clk_decode.sv
module pllb_clk_decode #(
  parameter int REG_COUNT = 16,
  parameter int REF_IDX   = 2,
  parameter int POST_IDX  = 5,
  parameter int EXT_IDX   = 6,
  parameter int FB_BASE   = 7
) (
  input  logic [REG_COUNT*8-1:0] file_flat,
  input  logic [1:0]             pclk_sel,
  output logic [7:0]             pclk_fb_div,
  output logic [2:0]             pclk_post_code,
  output logic [2:0]             mclk_post_sel,
  output logic [7:0]             ref_div
);
  import pllb_pkg::*;

  logic [7:0] post_reg, ext_reg;
  assign post_reg      = file_flat[POST_IDX*8 +: 8];
  assign ext_reg       = file_flat[EXT_IDX*8 +: 8];
  assign ref_div       = file_flat[REF_IDX*8 +: 8];
  assign mclk_post_sel = ext_reg[2:0];

  always_comb begin
    pclk_fb_div    = 8'h00;
    pclk_post_code = 3'b000;
    for (int n = 0; n < NUM_PCLK; n++) begin
      if (pclk_sel == 2'(n)) begin
        pclk_fb_div    = file_flat[(FB_BASE + n)*8 +: 8];
        pclk_post_code = {ext_reg[ext_bit(n)], post_reg[post_lsb(n) +: 2]};
      end
    end
  end
endmodule

// File: rtl/pll_cfg_bridge.sv
module pll_cfg_bridge #(
  parameter int         IDX_W     = 6,
  parameter int         REG_COUNT = 16,
  parameter int         REF_IDX   = 2,
  parameter int         POST_IDX  = 5,
  parameter int         EXT_IDX   = 6,
  parameter int         FB_BASE   = 7,
  parameter logic [7:0] REF_RST   = 8'h40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_sel,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic [1:0] pclk_sel,
  output logic [7:0] pclk_fb_div,
  output logic [2:0] pclk_post_code,
  output logic [2:0] mclk_post_sel,
  output logic [7:0] ref_div
);
  localparam int FLAT_W = REG_COUNT * 8;

  // named internal events
  logic addr_wr_ev, data_wr_ev, rd_ev;
  assign addr_wr_ev = host_wr && !host_sel;
  assign data_wr_ev = host_wr &&  host_sel;
  assign rd_ev      = host_rd;

  logic [7:0]        addr_byte;
  logic [IDX_W-1:0]  idx;
  logic              we;
  logic [7:0]        rd_word;
  logic [FLAT_W-1:0] file_flat;
  logic [7:0]        rd_next;

  pllb_addr_port #(.IDX_W(IDX_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .wr_ev(addr_wr_ev), .wdata(host_wdata),
    .addr_byte(addr_byte), .idx(idx), .we(we));

  pllb_regfile #(.IDX_W(IDX_W), .REG_COUNT(REG_COUNT), .REF_IDX(REF_IDX),
                 .REF_RST(REF_RST)) u_file (
    .clk(clk), .rst_n(rst_n), .wr_ev(data_wr_ev), .we(we), .idx(idx),
    .wdata(host_wdata), .rd_word(rd_word), .file_flat(file_flat));

  pllb_clk_decode #(.REG_COUNT(REG_COUNT), .REF_IDX(REF_IDX), .POST_IDX(POST_IDX),
                    .EXT_IDX(EXT_IDX), .FB_BASE(FB_BASE)) u_dec (
    .file_flat(file_flat), .pclk_sel(pclk_sel), .pclk_fb_div(pclk_fb_div),
    .pclk_post_code(pclk_post_code), .mclk_post_sel(mclk_post_sel),
    .ref_div(ref_div));

  assign rd_next = host_sel ? rd_word : addr_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     host_rdata <= 8'h00;
    else if (rd_ev) host_rdata <= rd_next;
  end

  p_rd_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev |=> (host_rdata == $past(rd_next)));
  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ev |=> $stable(host_rdata));
  p_addr_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && !host_sel) |=> (host_rdata[0] == 1'b0));
endmodule

// File: tb/pll_cfg_bridge_tb.sv
module pll_cfg_bridge_tb;
  localparam int         REG_COUNT = 16;
  localparam int         REF_IDX   = 2;
  localparam int         POST_IDX  = 5;
  localparam int         EXT_IDX   = 6;
  localparam int         FB_BASE   = 7;
  localparam logic [7:0] REF_RST   = 8'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic [1:0] pclk_sel = 2'd0;
  logic [7:0] pclk_fb_div, ref_div;
  logic [2:0] pclk_post_code, mclk_post_sel;

  always #4 clk = ~clk;

  pll_cfg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pclk_sel(pclk_sel), .pclk_fb_div(pclk_fb_div),
    .pclk_post_code(pclk_post_code), .mclk_post_sel(mclk_post_sel),
    .ref_div(ref_div));

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model [64];
  logic [7:0] m_addr;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_code(input int n);
    logic [7:0] p = model[POST_IDX], e = model[EXT_IDX];
    return {e[4 + n], p[2*n +: 2]};
  endfunction

  task automatic bus_wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    if (!sel) m_addr = {d[7:1], 1'b0};
    else if (m_addr[1] && m_addr[7:2] < 6'(REG_COUNT)) model[m_addr[7:2]] = d;
  endtask

  task automatic bus_rd(input logic sel, output logic [7:0] q);
    @(negedge clk);
    host_sel = sel; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    q = host_rdata;
  endtask

  function automatic logic [7:0] exp_rd(input logic sel);
    if (!sel) return m_addr;
    return (m_addr[7:2] < 6'(REG_COUNT)) ? model[m_addr[7:2]] : 8'h00;
  endfunction

  task automatic host_write(input int idx, input logic [7:0] d);
    bus_wr(1'b0, {6'(idx), 2'b10});
    bus_wr(1'b1, d);
    bus_wr(1'b0, {6'(idx), 2'b00});
  endtask

  task automatic check_decode();
    for (int n = 0; n < 4; n++) begin
      pclk_sel = 2'(n);
      #1;
      chk("R7 fb_div", pclk_fb_div, model[FB_BASE + n]);
      chk("R8 post_code", {5'd0, pclk_post_code}, {5'd0, exp_code(n)});
    end
    chk("R9 mclk_post_sel", {5'd0, mclk_post_sel}, {5'd0, model[EXT_IDX][2:0]});
    chk("R9 ref_div", ref_div, model[REF_IDX]);
  endtask

  initial begin
    logic [7:0] q;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    model[REF_IDX] = REF_RST;
    m_addr = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 rdata", host_rdata, 8'h00);
    bus_rd(1'b0, q); chk("R1 addr", q, 8'h00);
    for (int i = 0; i < REG_COUNT; i++) begin
      bus_wr(1'b0, {6'(i), 2'b00});
      bus_rd(1'b1, q); chk("R1 reg", q, model[i]);
    end
    check_decode();

    // R2: bit 0 masked, readback of address byte
    bus_wr(1'b0, 8'hFF); bus_rd(1'b0, q); chk("R2 addr", q, 8'hFE);
    bus_wr(1'b0, 8'h15); bus_rd(1'b0, q); chk("R2 addr", q, 8'h14);

    // R3 / R5: write then read, then hold
    host_write(FB_BASE, 8'hA5);
    bus_rd(1'b1, q); chk("R3 store", q, 8'hA5);
    repeat (3) @(negedge clk);
    chk("R5 hold", host_rdata, 8'hA5);

    // R4: data write with WE clear ignored
    bus_wr(1'b0, {6'(FB_BASE), 2'b00});
    bus_wr(1'b1, 8'h3C);
    bus_rd(1'b1, q); chk("R4 ignored", q, 8'hA5);

    // R6: out-of-range index
    bus_wr(1'b0, {6'd40, 2'b10});
    bus_wr(1'b1, 8'h77);
    bus_rd(1'b1, q); chk("R6 oob read", q, 8'h00);
    for (int i = 0; i < REG_COUNT; i++) begin
      bus_wr(1'b0, {6'(i), 2'b00});
      bus_rd(1'b1, q); chk("R6 no change", q, model[i]);
    end

    // R8: all post bits set, then individual bits
    host_write(POST_IDX, 8'hFF); host_write(EXT_IDX, 8'hF7);
    check_decode();
    host_write(POST_IDX, 8'h1B); host_write(EXT_IDX, 8'h52);
    check_decode();

    // random traffic mixed across both ports
    for (int k = 0; k < 600; k++) begin
      int op = int'($urandom_range(0, 5));
      logic [7:0] d = 8'($urandom);
      if (op == 0)      bus_wr(1'b0, d);
      else if (op == 1) bus_wr(1'b1, d);
      else if (op == 2) begin
        int ix = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 63))
                                             : int'($urandom_range(0, REG_COUNT - 1));
        host_write(ix, d);
      end
      else if (op == 3) begin bus_rd(1'b0, q); chk("R2 rand addr", q, exp_rd(1'b0)); end
      else if (op == 4) begin bus_rd(1'b1, q); chk("R5 rand data", q, exp_rd(1'b1)); end
      else check_decode();
    end
    check_decode();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule